// File: doc/BRIEF.md
# IO Interrupt Routing Controller

This block collects 32 device interrupt request lines and delivers each of them to one interrupt line of one processor core in the same chip. There are 4 cores with 4 interrupt pins each, so there are 16 output lines. Every source has its own enable bit, its own trigger mode (level or edge) and its own routing target, which is a core number and a pin number. Software programs all of this through a small synchronous register port. The same port reads back configuration and pending state, and clears latched edge requests.

In level mode, a source's pending state is its input. In edge mode, a rising edge seen at a clock edge sets a sticky pending bit that stays set until software clears it. An output line is driven high whenever at least one enabled, pending source is routed to it. The enable acts as a gate on the output only: it does not control whether an edge is captured.

The reset input is asserted asynchronously and released inside the block through a two-stage synchronizer.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every enable bit, mode bit, route field and sticky pending bit is 0, and `core_irq` is all zero.
- R2: The register map is as follows. Address 0 holds the enable mask (bit s is source s). Address 1 holds the mode mask (bit s = 1 selects edge mode for source s). Both read back what was written. Addresses 3 and 8 to 15 read as 0, and writes to them change nothing.
- R3: The route field of source s is at address 4 + s/8, bits [4*(s%8)+3 : 4*(s%8)]. Its upper 2 bits select the core and its lower 2 bits select the pin. The pair (core c, pin p) drives `core_irq[4*c+p]`.
- R4: In level mode, the pending state of a source equals its input in the same cycle, with no register delay.
- R5: In edge mode, a 0-to-1 change of a source, sampled at a clock edge, sets its pending bit. The bit is visible after that edge and stays set after the input falls.
- R6: A write to address 2 clears every edge pending bit whose data bit is 1 and leaves the others untouched. If a rising edge and a clear for the same source arrive in the same cycle, the edge wins.
- R7: Each `core_irq` line is the OR of all sources that are enabled, pending and routed to that line.
- R8: Clearing a source's enable removes its contribution at once. Its edge pending bit is kept, and edges are still captured while the source is disabled.
- R9: A read of address 2 returns the pending state of all 32 sources, regardless of their enable bits.
- R10: While a source is in level mode its sticky bit is held at 0, so switching it to edge mode starts with nothing pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dev_irq | input | 32 | Device interrupt request lines, synchronous to clk |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational |
| core_irq | output | 16 | Interrupt lines, index 4*core+pin |

## Verification
The hardest situation to reach from the ports is an edge request that is latched while its source is disabled, cleared by software while still disabled, and then latched again just before the source is re-enabled. A related case is a clear write that lands in the same cycle as a new rising edge. The bench reaches both by placing the source pulse and the register write on the same falling clock edge. It then reads the raw status word and the output lines at the next falling edge, to see which event won. It also moves a source between level and edge mode while a latched request is outstanding, to show that the stale request does not reappear.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  parameter int unsigned NSRC_DEF  = 32;
  parameter int unsigned NCORE_DEF = 4;
  parameter int unsigned NPIN_DEF  = 4;
  parameter int unsigned ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] A_ENABLE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(4);
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic edge_mode_i,
  input  logic clr_i,
  output logic pending_o
);
  logic prev_q, prev_d;
  logic sticky_q, sticky_d;
  logic rise;

  assign rise = src_i & ~prev_q;

  always_comb begin
    prev_d   = src_i;
    sticky_d = sticky_q;
    if (!edge_mode_i)  sticky_d = 1'b0;
    else if (rise)     sticky_d = 1'b1;
    else if (clr_i)    sticky_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      prev_q   <= prev_d;
      sticky_q <= sticky_d;
    end
  end

  assign pending_o = edge_mode_i ? sticky_q : src_i;

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && $rose(src_i) |=> (pending_o || !edge_mode_i)); // R5
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && $past(edge_mode_i) && $past(pending_o) && !$past(clr_i)
    |-> pending_o); // R5
  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && clr_i && !$rose(src_i) |=> (!pending_o || !edge_mode_i)); // R6
  AST_MODE_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    edge_mode_i && !$past(edge_mode_i) |-> !pending_o); // R10
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC    = NSRC_DEF,
  parameter int unsigned ROUTE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NSRC-1:0]          wdata_i,
  input  logic [NSRC-1:0]          pend_i,
  output logic [NSRC-1:0]          rdata_o,
  output logic [NSRC-1:0]          en_o,
  output logic [NSRC-1:0]          edge_o,
  output logic [NSRC*ROUTE_W-1:0]  route_o,
  output logic [NSRC-1:0]          clr_o
);
  localparam int unsigned NWORDS = ROUTE_W;

  logic [NSRC-1:0]         en_q, en_d, edge_q, edge_d;
  logic [NSRC*ROUTE_W-1:0] route_q, route_d;
  logic                    hit_route;
  logic [ADDR_W-1:0]       widx;

  assign hit_route = (addr_i >= A_ROUTE) && (addr_i < A_ROUTE + ADDR_W'(NWORDS));
  assign widx      = addr_i - A_ROUTE;

  always_comb begin
    en_d    = en_q;
    edge_d  = edge_q;
    route_d = route_q;
    if (we_i && addr_i == A_ENABLE) en_d   = wdata_i;
    if (we_i && addr_i == A_MODE)   edge_d = wdata_i;
    if (we_i && hit_route)          route_d[widx*NSRC +: NSRC] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      edge_q  <= '0;
      route_q <= '0;
    end else begin
      en_q    <= en_d;
      edge_q  <= edge_d;
      route_q <= route_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_ENABLE)     rdata_o = en_q;
    else if (addr_i == A_MODE)  rdata_o = edge_q;
    else if (addr_i == A_PEND)  rdata_o = pend_i;
    else if (hit_route)         rdata_o = route_q[widx*NSRC +: NSRC];
  end

  assign clr_o   = (we_i && addr_i == A_PEND) ? wdata_i : '0;
  assign en_o    = en_q;
  assign edge_o  = edge_q;
  assign route_o = route_q;

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == A_ENABLE) |=> $stable(en_o)); // R2
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && addr_i == A_MODE) |=> $stable(edge_o)); // R2
endmodule

// File: rtl/irq_route_merge.sv
module irq_route_merge #(
  parameter int unsigned NSRC    = 32,
  parameter int unsigned NLINE   = 16,
  parameter int unsigned ROUTE_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSRC-1:0]         pend_i,
  input  logic [NSRC-1:0]         en_i,
  input  logic [NSRC*ROUTE_W-1:0] route_i,
  output logic [NLINE-1:0]        line_o
);
  logic [NSRC-1:0] live;
  assign live = pend_i & en_i;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    always_comb begin
      line_o[l] = 1'b0;
      for (int s = 0; s < NSRC; s++)
        if (live[s] && route_i[s*ROUTE_W +: ROUTE_W] == ROUTE_W'(l))
          line_o[l] = 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (live == '0) |-> (line_o == '0)); // R7
  AST_LINE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(line_o) <= $countones(live)); // R7
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned NSRC  = NSRC_DEF,
  parameter int unsigned NCORE = NCORE_DEF,
  parameter int unsigned NPIN  = NPIN_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          dev_irq,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [NSRC-1:0]          cfg_wdata,
  output logic [NSRC-1:0]          cfg_rdata,
  output logic [NCORE*NPIN-1:0]    core_irq
);
  localparam int unsigned CORE_W  = $clog2(NCORE);
  localparam int unsigned PIN_W   = $clog2(NPIN);
  localparam int unsigned ROUTE_W = CORE_W + PIN_W;
  localparam int unsigned NLINE   = NCORE * NPIN;

  logic [1:0]              rsync_q;
  logic                    rst_int_n;
  logic [NSRC-1:0]         pend, en, edge_sel, clr;
  logic [NSRC*ROUTE_W-1:0] route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    irq_src_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .src_i      (dev_irq[s]),
      .edge_mode_i(edge_sel[s]),
      .clr_i      (clr[s]),
      .pending_o  (pend[s])
    );
  end

  irq_route_regs #(.NSRC(NSRC), .ROUTE_W(ROUTE_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .we_i   (cfg_we),
    .addr_i (cfg_addr),
    .wdata_i(cfg_wdata),
    .pend_i (pend),
    .rdata_o(cfg_rdata),
    .en_o   (en),
    .edge_o (edge_sel),
    .route_o(route),
    .clr_o  (clr)
  );

  irq_route_merge #(.NSRC(NSRC), .NLINE(NLINE), .ROUTE_W(ROUTE_W)) u_merge (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .pend_i (pend),
    .en_i   (en),
    .route_i(route),
    .line_o (core_irq)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (core_irq == '0)); // R1
endmodule

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] dev_irq;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [15:0] core_irq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .core_irq(core_irq)
  );

  // {enable mask, source pattern, expected core_irq}; source s routed to line s%16
  localparam logic [79:0] VEC [10] = '{
    {32'hFFFF_FFFF, 32'h0000_0001, 16'h0001},
    {32'hFFFF_FFFF, 32'h0001_0000, 16'h0001},
    {32'hFFFF_FFFF, 32'h8000_0000, 16'h8000},
    {32'hFFFF_FFFF, 32'hA5A5_0000, 16'hA5A5},
    {32'h0000_FFFF, 32'hFFFF_0000, 16'h0000},
    {32'hFFFF_0000, 32'h0000_FFFF, 16'h0000},
    {32'hFFFF_0000, 32'h1234_0000, 16'h1234},
    {32'h0F0F_0F0F, 32'hFFFF_FFFF, 16'h0F0F},
    {32'h0000_0000, 32'hFFFF_FFFF, 16'h0000},
    {32'hFFFF_FFFF, 32'h00F0_0F00, 16'h0FF0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; dev_irq = 32'hFFFF_FFFF; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 irq during reset", {16'h0, core_irq}, 32'h0);
    dev_irq = '0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 irq after reset", {16'h0, core_irq}, 32'h0);
    for (int a = 0; a < 8; a++) begin
      rd(a[3:0], rv);
      check("R1 register reset value", rv, 32'h0);
    end

    // unmapped addresses
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, rv); check("R2 addr 3 reads zero", rv, 32'h0);
    wr(4'd9, 32'h1234_5678);
    rd(4'd9, rv); check("R2 addr 9 reads zero", rv, 32'h0);
    for (int a = 4; a < 8; a++) begin
      rd(a[3:0], rv);
      check("R2 unmapped write leaves routes", rv, 32'h0);
    end

    // route source s to line s%16 (core s[3:2], pin s[1:0])
    wr(4'd4, 32'h7654_3210);
    wr(4'd5, 32'hFEDC_BA98);
    wr(4'd6, 32'h7654_3210);
    wr(4'd7, 32'hFEDC_BA98);
    rd(4'd5, rv); check("R2 route readback", rv, 32'hFEDC_BA98);
    wr(4'd1, 32'h0);
    rd(4'd1, rv); check("R2 mode readback", rv, 32'h0);

    // level-mode table walk
    foreach (VEC[i]) begin
      wr(4'd0, VEC[i][79:48]);
      rd(4'd0, rv); check("R2 enable readback", rv, VEC[i][79:48]);
      dev_irq = VEC[i][47:16];
      #1;
      check("R7 R4 level routing", {16'h0, core_irq}, {16'h0, VEC[i][15:0]});
      rd(4'd2, rv); check("R9 R4 raw status", rv, VEC[i][47:16]);
    end
    dev_irq = '0;
    #1;
    check("R4 level drops with input", {16'h0, core_irq}, 32'h0);

    // reroute source 5 to core 3 pin 2 (line 14)
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd4, 32'h76E4_3210);
    dev_irq = 32'h0000_0020;
    #1;
    check("R3 reroute source 5", {16'h0, core_irq}, 32'h0000_4000);
    dev_irq = '0;

    // edge mode on source 3 (line 3)
    wr(4'd1, 32'h0000_0008);
    @(negedge clk); dev_irq = 32'h8;
    @(negedge clk); dev_irq = 32'h0;
    #1;
    check("R5 edge latched after input falls", {16'h0, core_irq}, 32'h0008);
    rd(4'd2, rv); check("R9 R5 raw edge pending", rv, 32'h8);
    wr(4'd2, 32'h0);
    rd(4'd2, rv); check("R6 write 0 keeps pending", rv, 32'h8);
    wr(4'd0, 32'hFFFF_FFF7);
    #1;
    check("R8 disable drops output", {16'h0, core_irq}, 32'h0);
    rd(4'd2, rv); check("R8 disable keeps pending", rv, 32'h8);
    wr(4'd2, 32'h8);
    rd(4'd2, rv); check("R6 write 1 clears", rv, 32'h0);
    @(negedge clk); dev_irq = 32'h8;
    @(negedge clk); dev_irq = 32'h0;
    rd(4'd2, rv); check("R8 edge captured while disabled", rv, 32'h8);
    check("R8 disabled output quiet", {16'h0, core_irq}, 32'h0);
    wr(4'd0, 32'hFFFF_FFFF);
    #1;
    check("R8 re-enable restores output", {16'h0, core_irq}, 32'h0008);

    // mode round trip drops stale request
    wr(4'd1, 32'h0);
    rd(4'd2, rv); check("R10 level mode shows input", rv, 32'h0);
    wr(4'd1, 32'h8);
    rd(4'd2, rv); check("R10 edge mode starts clean", rv, 32'h0);
    check("R10 output after mode return", {16'h0, core_irq}, 32'h0);

    // rising edge and clear in the same cycle
    @(negedge clk);
    dev_irq = 32'h8; cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = 32'h8;
    @(negedge clk);
    cfg_we = 1'b0; dev_irq = 32'h0;
    rd(4'd2, rv); check("R6 edge wins over clear", rv, 32'h8);
    wr(4'd2, 32'hFFFF_FFFF);
    rd(4'd2, rv); check("R6 final clear", rv, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule